// File: doc/BRIEF.md
# Three-Phase Power Combiner with Reverse-Flow Flag

This block sits between the per-phase power calculation and the pulse generators of a polyphase energy meter. Each cycle that a sample strobe is high, it takes one signed real-power sample per phase and forms a registered total. A mode input selects how the phases combine. In the net mode the phases add with their signs. In the magnitude mode each phase adds as its absolute value, so power flowing in either direction counts as consumed energy.

Beside the total, the block drives a reverse-flow flag that shows whether any phase is currently carrying negative power. The flag follows the present condition and is not a sticky alarm. It moves only at pulse boundaries: every accepted sample refreshes a pending verdict, and the output takes that verdict when the pulse generator reports the start of a calibration pulse. A phase marked as below the no-load level does not count toward the verdict while the mark is present.

Top module: `phase_power_combiner`

## Requirements
- R1: After reset, `total_pwr` is 0 and `rev_flag` is 0.
- R2: With `net_mode` = 1, the cycle after `sample_valid` is high, `total_pwr` equals the signed sum of the phase samples (phase k occupies bits [k*PWR_W +: PWR_W] of `phase_pwr`, two's complement).
- R3: With `net_mode` = 0, the cycle after `sample_valid` is high, `total_pwr` equals the sum of the absolute values of the phase samples. It is never negative and never overflows, including when every phase holds the most negative code. `total_pwr` is PWR_W + clog2(NPH) + 1 bits wide.
- R4: When `sample_valid` is low, `total_pwr` holds its value whatever the other inputs do.
- R5: `rev_flag` changes only in the cycle after `cf_start` is high. In every other cycle it holds, even when new samples arrive.
- R6: Each accepted sample sets a pending verdict. The verdict is 1 if any counted phase is negative. It is 0 if every counted phase is zero or positive. On `cf_start`, `rev_flag` takes the pending verdict, so it falls again once all phases are non-negative.
- R7: A phase whose `noload` bit (bit k for phase k) is high when a sample is accepted is left out of the verdict for that sample. The phase counts again on the first sample taken with its bit low.
- R8: The verdict does not depend on `net_mode`. It is computed the same way in both modes.
- R9: When `cf_start` and `sample_valid` are high in the same cycle, `rev_flag` takes the verdict from the earlier sample. The new sample's verdict waits for the next `cf_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Phase samples are valid this cycle |
| phase_pwr | input | NPH*PWR_W | Signed per-phase power samples, phase k at [k*PWR_W +: PWR_W] |
| net_mode | input | 1 | 1: signed sum, 0: sum of magnitudes |
| noload | input | NPH | Per-phase no-load marks, bit k for phase k |
| cf_start | input | 1 | A calibration pulse starts this cycle |
| total_pwr | output | PWR_W+clog2(NPH)+1 | Registered combined power, signed |
| rev_flag | output | 1 | Reverse-flow flag |

## Verification
The bench builds the block with three phases and PWR_W = 8. At that width random samples hit the most negative code, zero and full-scale positive values often, so the overflow margin in both modes is tested in ordinary random traffic. Directed cases cover the signs of all three phases at full negative scale, a negative phase hidden by its no-load mark, and a sample arriving in the same cycle as a pulse start. Random strobes and modes then run the pending-then-publish order of the reverse flag in both summation modes against a bench model.

// File: rtl/combiner_pkg.sv
package combiner_pkg;

    localparam int DEF_PWR_W = 24;
    localparam int DEF_NPH   = 3;

    typedef enum logic {
        SUM_MAGNITUDE = 1'b0,
        SUM_NET       = 1'b1
    } sum_mode_e;

    // Width that holds NPH full-scale magnitudes without overflow:
    // one bit for the magnitude of the most negative code, clog2(NPH) for growth.
    function automatic int total_width(input int pwr_w, input int nph);
        return pwr_w + $clog2(nph) + 1;
    endfunction

endpackage

// File: rtl/phase_term.sv
module phase_term
    import combiner_pkg::*;
#(
    parameter int PWR_W = DEF_PWR_W,
    parameter int SUM_W = total_width(DEF_PWR_W, DEF_NPH)
) (
    input  logic [PWR_W-1:0]        sample,
    input  sum_mode_e               mode,
    input  logic                    idle,
    output logic signed [SUM_W-1:0] term,
    output logic                    reverse
);
    localparam int EXT_W = SUM_W - PWR_W;

    logic signed [SUM_W-1:0] widened;
    logic                    is_neg;

    always_comb begin
        is_neg  = sample[PWR_W-1];
        widened = {{EXT_W{is_neg}}, sample};
        if (mode == SUM_MAGNITUDE && is_neg) begin
            term = -widened;
        end else begin
            term = widened;
        end
        reverse = is_neg && !idle;
    end

endmodule

// File: rtl/term_sum.sv
module term_sum
    import combiner_pkg::*;
#(
    parameter int NPH   = DEF_NPH,
    parameter int SUM_W = total_width(DEF_PWR_W, DEF_NPH)
) (
    input  logic [NPH*SUM_W-1:0]    terms,
    output logic signed [SUM_W-1:0] sum
);
    always_comb begin
        sum = '0;
        for (int k = 0; k < NPH; k++) begin
            sum = sum + $signed(terms[k*SUM_W +: SUM_W]);
        end
    end

endmodule

// File: rtl/rev_track.sv
module rev_track
    import combiner_pkg::*;
#(
    parameter int NPH = DEF_NPH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample_valid,
    input  logic           cf_start,
    input  logic [NPH-1:0] reverse,
    output logic           flag
);
    typedef struct packed {
        logic pending;
        logic flag;
    } rev_state_t;

    rev_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            st_d.pending = |reverse;
        end
        if (cf_start) begin
            st_d.flag = st_q.pending;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/phase_power_combiner.sv
module phase_power_combiner
    import combiner_pkg::*;
#(
    parameter int PWR_W = DEF_PWR_W,
    parameter int NPH   = DEF_NPH
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     sample_valid,
    input  logic [NPH*PWR_W-1:0]                     phase_pwr,
    input  logic                                     net_mode,
    input  logic [NPH-1:0]                           noload,
    input  logic                                     cf_start,
    output logic signed [total_width(PWR_W,NPH)-1:0] total_pwr,
    output logic                                     rev_flag
);
    localparam int SUM_W = total_width(PWR_W, NPH);

    typedef struct packed {
        logic signed [SUM_W-1:0] total;
    } sum_state_t;

    sum_state_t st_d, st_q;

    sum_mode_e               mode;
    logic [NPH*SUM_W-1:0]    terms;
    logic [NPH-1:0]          reverse;
    logic signed [SUM_W-1:0] sum;

    assign mode = sum_mode_e'(net_mode);

    for (genvar k = 0; k < NPH; k++) begin : g_phase
        phase_term #(
            .PWR_W(PWR_W),
            .SUM_W(SUM_W)
        ) u_term (
            .sample (phase_pwr[k*PWR_W +: PWR_W]),
            .mode   (mode),
            .idle   (noload[k]),
            .term   (terms[k*SUM_W +: SUM_W]),
            .reverse(reverse[k])
        );
    end

    term_sum #(
        .NPH  (NPH),
        .SUM_W(SUM_W)
    ) u_sum (
        .terms(terms),
        .sum  (sum)
    );

    rev_track #(
        .NPH(NPH)
    ) u_rev (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .cf_start    (cf_start),
        .reverse     (reverse),
        .flag        (rev_flag)
    );

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            st_d.total = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign total_pwr = st_q.total;

endmodule

// File: rtl/combiner_checker.sv
module combiner_checker #(
    parameter int NPH   = 3,
    parameter int SUM_W = 27
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sample_valid,
    input logic                    net_mode,
    input logic [NPH-1:0]          noload,
    input logic                    cf_start,
    input logic signed [SUM_W-1:0] total_pwr,
    input logic                    rev_flag
);
    p_total_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(total_pwr));

    p_abs_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !net_mode) |=> !total_pwr[SUM_W-1]);

    p_rev_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cf_start |=> $stable(rev_flag));

    p_noload_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (&noload)) ##1 cf_start |=> !rev_flag);

endmodule

bind phase_power_combiner combiner_checker #(
    .NPH  (NPH),
    .SUM_W(SUM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .net_mode    (net_mode),
    .noload      (noload),
    .cf_start    (cf_start),
    .total_pwr   (total_pwr),
    .rev_flag    (rev_flag)
);

// File: tb/phase_power_combiner_test.sv
module phase_power_combiner_test;
    localparam int W   = 8;
    localparam int NPH = 3;
    localparam int SW  = combiner_pkg::total_width(W, NPH);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_valid = 1'b0;
    logic [NPH*W-1:0]     phase_pwr = '0;
    logic                 net_mode = 1'b1;
    logic [NPH-1:0]       noload = '0;
    logic                 cf_start = 1'b0;
    logic signed [SW-1:0] total_pwr;
    logic                 rev_flag;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;
    longint exp_total = 0;
    bit  exp_pend = 0;
    bit  exp_rev = 0;

    always #4 clk = ~clk;

    phase_power_combiner #(.PWR_W(W), .NPH(NPH)) uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .phase_pwr(phase_pwr), .net_mode(net_mode), .noload(noload),
        .cf_start(cf_start), .total_pwr(total_pwr), .rev_flag(rev_flag)
    );

    function automatic longint ph_val(input logic [NPH*W-1:0] v, input int k);
        logic signed [W-1:0] s;
        s = v[k*W +: W];
        return longint'(s);
    endfunction

    function automatic longint model_total(input logic [NPH*W-1:0] v, input bit net);
        longint acc = 0;
        for (int k = 0; k < NPH; k++) begin
            longint x = ph_val(v, k);
            acc += (!net && x < 0) ? -x : x;
        end
        return acc;
    endfunction

    function automatic bit model_rev(input logic [NPH*W-1:0] v, input logic [NPH-1:0] nl);
        bit r = 0;
        for (int k = 0; k < NPH; k++) begin
            if (!nl[k] && ph_val(v, k) < 0) r = 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge pass, update model, check at next negedge.
    task automatic step(input bit v, input bit net, input logic [NPH*W-1:0] ph,
                        input logic [NPH-1:0] nl, input bit cf,
                        input string ttag, input string rtag);
        sample_valid = v; net_mode = net; phase_pwr = ph; noload = nl; cf_start = cf;
        @(posedge clk);
        if (cf) exp_rev = exp_pend;
        if (v) begin
            exp_pend  = model_rev(ph, nl);
            exp_total = model_total(ph, net);
        end
        @(negedge clk);
        check(ttag, longint'(total_pwr), exp_total);
        check(rtag, longint'(rev_flag), longint'(exp_rev));
    endtask

    function automatic logic [NPH*W-1:0] pack3(input int a, input int b, input int c);
        logic [W-1:0] x = W'(a), y = W'(b), z = W'(c);
        return {z, y, x};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check("R1 total", longint'(total_pwr), 0);
        check("R1 rev", longint'(rev_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 signed sum, mixed signs
        step(1, 1, pack3(100, -30, 7), 3'b000, 0, "R2", "R5");
        // R4 hold: inputs change, no strobe; R5 rev holds despite pending=1
        step(0, 0, pack3(-128, -128, -128), 3'b000, 0, "R4", "R5");
        // R6 publish pending negative
        step(0, 1, '0, 3'b000, 1, "R4", "R6");
        // R3 full negative scale in magnitude mode: 384
        step(1, 0, pack3(-128, -128, -128), 3'b000, 0, "R3", "R5");
        // R2 full negative scale in signed mode: -384
        step(1, 1, pack3(-128, -128, -128), 3'b000, 0, "R2", "R5");
        // R3 full positive scale in magnitude mode
        step(1, 0, pack3(127, 127, 127), 3'b000, 0, "R3", "R5");
        // R6 zero counts non-negative; flag falls
        step(1, 1, pack3(0, 0, 0), 3'b000, 0, "R2", "R6");
        step(0, 1, '0, 3'b000, 1, "R4", "R6");
        // R7 negative phase hidden by noload
        step(1, 1, pack3(5, -9, 5), 3'b010, 0, "R2", "R7");
        step(0, 1, '0, 3'b000, 1, "R4", "R7");
        // R7 counts again once mark cleared
        step(1, 1, pack3(5, -9, 5), 3'b000, 0, "R2", "R7");
        step(0, 1, '0, 3'b000, 1, "R4", "R7");
        // R8 magnitude mode still detects reverse; R9 same-cycle sample waits
        step(1, 0, pack3(1, 2, 3), 3'b000, 0, "R3", "R8");
        step(1, 0, pack3(-1, 2, 3), 3'b000, 1, "R3", "R9");
        step(0, 0, '0, 3'b000, 1, "R4", "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [NPH*W-1:0] ph;
            logic [NPH-1:0]   nl;
            bit v, net, cf;
            for (int k = 0; k < NPH; k++) begin
                case ($urandom % 6)
                    0: ph[k*W +: W] = {1'b1, {(W-1){1'b0}}};
                    1: ph[k*W +: W] = '0;
                    2: ph[k*W +: W] = {1'b0, {(W-1){1'b1}}};
                    default: ph[k*W +: W] = W'($urandom);
                endcase
                nl[k] = ($urandom % 4) == 0;
            end
            v   = ($urandom % 4) != 0;
            net = $urandom % 2;
            cf  = ($urandom % 4) == 0;
            step(v, net, ph, nl, cf, v ? (net ? "R2" : "R3") : "R4", cf ? "R6" : "R5");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule